// File: doc/BRIEF.md
# SD Data Phase Error Detector

This block watches the single SD data line (DAT0) during block transfers and records data-phase faults in sticky flags. A read begins with a start pulse. The block then waits for the card's start bit and shifts in one block of payload followed by its 16-bit CRC. It checks the CRC and the closing end bit. If the start bit is late, it reports a time-out.

A write begins with a start pulse issued once the host has driven the end bit of its block. The block waits a short window for the card's CRC status token. It checks the three token bits and the token's end bit, then times the busy period in which the card holds DAT0 low. A separate start pulse times busy alone, for the busy phase that follows a busy-type command response.

Faults are collected in three flags. Each flag stays set until software writes a 1 to its mask bit. All logic runs on the card clock, and DAT0 is sampled on each rising edge.

Top module: `sd_dat_err_mon`

## Requirements
- R1: After reset, `err_flags` is 3'b000 and `idle` is 1.
- R2: In a read, the first 0 sampled on DAT0 is the start bit. The next BLK_BYTES*8 bits are payload and the 16 bits after them are the CRC, each sent MSB first. The CRC is x^16+x^12+x^5+1 (0x1021), starts from zero and covers the payload only. A mismatch sets the CRC flag `err_flags[1]`.
- R3: In a read, a 0 sampled in the bit after the last CRC bit sets the end-bit flag `err_flags[0]`.
- R4: With `tmo_limit` = L, the read start bit is accepted in any of the first L+1 samples after `rd_start` is taken. If it has not come by then, the time-out flag `err_flags[2]` is set and the read is abandoned.
- R5: After `wr_start` is taken, the token start bit (0) must arrive within the first TOK_WIN samples. Otherwise `err_flags[2]` is set and the write check is abandoned.
- R6: The three token bits, MSB first, must equal 3'b010, or `err_flags[1]` is set. A 0 in the token's end-bit position sets `err_flags[0]`.
- R7: From the sample after the token end bit, DAT0 low means busy and DAT0 high ends it. If DAT0 is low for L+1 consecutive samples, `err_flags[2]` is set.
- R8: `busy_start` runs the same busy timing as R7 from the next sample, with no token phase.
- R9: Flags are sticky. On a cycle where `clr_stb` is 1, each flag whose `clr_mask` bit is 1 is cleared, and flags whose mask bit is 0 keep their value.
- R10: Start pulses are taken only when idle, and are ignored while a phase runs. If several start pulses arrive together, `rd_start` wins over `wr_start`, and `wr_start` wins over `busy_start`.
- R11: `idle` is 0 from the cycle after a start is taken until the phase ends, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat0 | input | 1 | DAT0 line level, synchronous to clk |
| rd_start | input | 1 | Start waiting for a read block |
| wr_start | input | 1 | Host end bit just sent; start waiting for the CRC status token |
| busy_start | input | 1 | Start timing busy after a busy-type response |
| tmo_limit | input | TMO_W | Time-out count L, loaded when each wait begins |
| clr_stb | input | 1 | Clear strobe for the flags |
| clr_mask | input | 3 | Flags to clear: bit 0 end bit, bit 1 CRC, bit 2 time-out |
| err_flags | output | 3 | Sticky flags: bit 0 end bit, bit 1 CRC, bit 2 time-out |
| idle | output | 1 | No phase in progress |

## Verification
The bench builds the block with BLK_BYTES=4, TMO_W=8 and TOK_WIN=4, and drives `tmo_limit` at 10. With these values a whole block with its CRC fits in about fifty cycles. The off-by-one edges of every wait can be placed exactly: a read start bit at gap 10 and 11, a token start bit at gap 3 and 4, and busy of 10 and 11 samples. Short blocks also make it cheap to pair bad CRC with bad end bit, and to inject start pulses in the middle of a payload.

// File: rtl/sd_dat_pkg.sv
package sd_dat_pkg;

   localparam int N_FLAGS = 3;
   localparam int FLG_END = 0;
   localparam int FLG_CRC = 1;
   localparam int FLG_TMO = 2;

   localparam int          CRC_W    = 16;
   localparam logic [15:0] CRC_POLY = 16'h1021;
   localparam logic [2:0]  TOKEN_OK = 3'b010;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_RD_WAIT = 3'd1,
      ST_RD_BITS = 3'd2,
      ST_RD_END  = 3'd3,
      ST_WR_WAIT = 3'd4,
      ST_WR_TOK  = 3'd5,
      ST_WR_END  = 3'd6,
      ST_BUSY    = 3'd7
   } mon_state_e;

endpackage

// File: rtl/sd_crc_serial.sv
module sd_crc_serial #(
   parameter int          W    = 16,
   parameter logic [W-1:0] POLY = 16'h1021
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc_nxt
);

   logic [W-1:0] crc_q;

   generate
      if (W < 2) begin : g_bad_w
         initial $fatal(1, "sd_crc_serial: W must be at least 2");
      end
   endgenerate

   always_comb begin
      crc_nxt = {crc_q[W-2:0], 1'b0} ^ ({W{crc_q[W-1] ^ din}} & POLY);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= '0;
      else if (clr)
         crc_q <= '0;
      else if (en)
         crc_q <= crc_nxt;
   end

endmodule

// File: rtl/sd_wait_timer.sv
module sd_wait_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         expired
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sd_w1c_flags.sv
module sd_w1c_flags #(
   parameter int N        = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic bit_q;
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else
               bit_q <= set[i] | (bit_q & ~clr[i]);
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else
               bit_q <= ~clr[i] & (bit_q | set[i]);
         end
      end
      assign q[i] = bit_q;
   end

endmodule

// File: rtl/sd_dat_err_mon.sv
module sd_dat_err_mon
   import sd_dat_pkg::*;
#(
   parameter int BLK_BYTES = 512,
   parameter int TMO_W     = 20,
   parameter int TOK_WIN   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dat0,
   input  logic             rd_start,
   input  logic             wr_start,
   input  logic             busy_start,
   input  logic [TMO_W-1:0] tmo_limit,
   input  logic             clr_stb,
   input  logic [2:0]       clr_mask,
   output logic [2:0]       err_flags,
   output logic             idle
);

   localparam int RD_TOTAL = BLK_BYTES * 8 + CRC_W;
   localparam int BIT_W    = $clog2(RD_TOTAL + 1);
   localparam int RD_LAST  = RD_TOTAL - 1;
   localparam int TOK_LAST = 2;

   generate
      if (BLK_BYTES < 1) begin : g_bad_blk
         initial $fatal(1, "sd_dat_err_mon: BLK_BYTES must be at least 1");
      end
      if (TOK_WIN < 1) begin : g_bad_win
         initial $fatal(1, "sd_dat_err_mon: TOK_WIN must be at least 1");
      end
      if (TMO_W < 2 || TMO_W > 30) begin : g_bad_tmo
         initial $fatal(1, "sd_dat_err_mon: TMO_W out of range");
      end
      if (TOK_WIN - 1 >= (1 << TMO_W)) begin : g_bad_fit
         initial $fatal(1, "sd_dat_err_mon: TOK_WIN does not fit in TMO_W");
      end
   endgenerate

   mon_state_e         state_q, state_d;
   logic [BIT_W-1:0]   bit_q;
   logic [1:0]         tok_q;
   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_clr;
   logic               tm_load, tm_dec, tm_expired;
   logic [TMO_W-1:0]   tm_val;
   logic               crc_clr, crc_en;
   logic [CRC_W-1:0]   crc_nxt;

   sd_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (crc_clr),
      .en      (crc_en),
      .din     (dat0),
      .crc_nxt (crc_nxt)
   );

   sd_wait_timer #(.W(TMO_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .dec      (tm_dec),
      .expired  (tm_expired)
   );

   sd_w1c_flags #(.N(N_FLAGS), .SET_WINS(1'b1)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .q     (err_flags)
   );

   assign flag_clr = clr_stb ? clr_mask : '0;
   assign idle     = (state_q == ST_IDLE);

   always_comb begin
      state_d  = state_q;
      flag_set = '0;
      tm_load  = 1'b0;
      tm_val   = tmo_limit;
      tm_dec   = 1'b0;
      crc_clr  = 1'b0;
      crc_en   = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (rd_start) begin
               state_d = ST_RD_WAIT;
               tm_load = 1'b1;
               crc_clr = 1'b1;
            end else if (wr_start) begin
               state_d = ST_WR_WAIT;
               tm_load = 1'b1;
               tm_val  = TMO_W'(TOK_WIN - 1);
            end else if (busy_start) begin
               state_d = ST_BUSY;
               tm_load = 1'b1;
            end
         end
         ST_RD_WAIT: begin
            if (!dat0) begin
               state_d = ST_RD_BITS;
            end else if (tm_expired) begin
               flag_set[FLG_TMO] = 1'b1;
               state_d = ST_IDLE;
            end else begin
               tm_dec = 1'b1;
            end
         end
         ST_RD_BITS: begin
            crc_en = 1'b1;
            if (bit_q == BIT_W'(RD_LAST)) begin
               flag_set[FLG_CRC] = (crc_nxt != '0);
               state_d = ST_RD_END;
            end
         end
         ST_RD_END: begin
            flag_set[FLG_END] = ~dat0;
            state_d = ST_IDLE;
         end
         ST_WR_WAIT: begin
            if (!dat0) begin
               state_d = ST_WR_TOK;
            end else if (tm_expired) begin
               flag_set[FLG_TMO] = 1'b1;
               state_d = ST_IDLE;
            end else begin
               tm_dec = 1'b1;
            end
         end
         ST_WR_TOK: begin
            if (bit_q == BIT_W'(TOK_LAST)) begin
               flag_set[FLG_CRC] = ({tok_q, dat0} != TOKEN_OK);
               state_d = ST_WR_END;
            end
         end
         ST_WR_END: begin
            flag_set[FLG_END] = ~dat0;
            tm_load = 1'b1;
            state_d = ST_BUSY;
         end
         ST_BUSY: begin
            if (dat0) begin
               state_d = ST_IDLE;
            end else if (tm_expired) begin
               flag_set[FLG_TMO] = 1'b1;
               state_d = ST_IDLE;
            end else begin
               tm_dec = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         tok_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_d != state_q)
            bit_q <= '0;
         else if (state_q == ST_RD_BITS || state_q == ST_WR_TOK)
            bit_q <= bit_q + 1'b1;
         if (state_q == ST_WR_TOK)
            tok_q <= {tok_q[0], dat0};
      end
   end

endmodule

// File: rtl/sd_dat_err_mon_chk.sv
module sd_dat_err_mon_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_start,
   input logic       wr_start,
   input logic       busy_start,
   input logic       clr_stb,
   input logic [2:0] clr_mask,
   input logic [2:0] err_flags,
   input logic       idle
);

   logic [2:0] clr_eff;
   logic [2:0] keep;
   logic       any_start;

   assign clr_eff   = clr_stb ? clr_mask : 3'b000;
   assign keep      = err_flags & ~clr_eff;
   assign any_start = rd_start | wr_start | busy_start;

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (keep != 3'b000) |=> ((err_flags & $past(keep)) == $past(keep)))
      else $error("a_r9_sticky");

   a_r9_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && idle) |=> ((err_flags & $past(clr_mask)) == 3'b000))
      else $error("a_r9_clear_when_idle");

   a_r11_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && any_start) |=> !idle)
      else $error("a_r11_launch");

   a_r11_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !any_start) |=> idle)
      else $error("a_r11_stay_idle");

   a_r10_rise_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
      ((err_flags & ~$past(err_flags)) != 3'b000) |-> !$past(idle))
      else $error("a_r10_rise_in_phase");

endmodule

bind sd_dat_err_mon sd_dat_err_mon_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_start   (rd_start),
   .wr_start   (wr_start),
   .busy_start (busy_start),
   .clr_stb    (clr_stb),
   .clr_mask   (clr_mask),
   .err_flags  (err_flags),
   .idle       (idle)
);

// File: tb/sd_dat_err_mon_tb.sv
module sd_dat_err_mon_tb;

   localparam int BLK_BYTES = 4;
   localparam int TMO_W     = 8;
   localparam int TOK_WIN   = 4;
   localparam int LIM       = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             dat0 = 1'b1;
   logic             rd_start = 1'b0, wr_start = 1'b0, busy_start = 1'b0;
   logic [TMO_W-1:0] tmo_limit = TMO_W'(LIM);
   logic             clr_stb = 1'b0;
   logic [2:0]       clr_mask = 3'b000;
   logic [2:0]       err_flags;
   logic             idle;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   sd_dat_err_mon #(.BLK_BYTES(BLK_BYTES), .TMO_W(TMO_W), .TOK_WIN(TOK_WIN)) u_dut (
      .clk(clk), .rst_n(rst_n), .dat0(dat0), .rd_start(rd_start),
      .wr_start(wr_start), .busy_start(busy_start), .tmo_limit(tmo_limit),
      .clr_stb(clr_stb), .clr_mask(clr_mask), .err_flags(err_flags), .idle(idle)
   );

   typedef struct packed {
      logic [1:0]  op;      // 0 read, 1 write, 2 busy only
      logic [31:0] data;
      logic [3:0]  gap;
      logic [3:0]  busy;
      logic        bad_crc;
      logic        bad_end;
      logic [2:0]  tok;
      logic [2:0]  exp;
   } vec_t;

   localparam vec_t VEC [15] = '{
      '{2'd0, 32'hA5C30F12, 4'd3,  4'd0,  1'b0, 1'b0, 3'b000, 3'b000},
      '{2'd0, 32'h00000000, 4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 3'b000},
      '{2'd0, 32'hFFFFFFFF, 4'd5,  4'd0,  1'b1, 1'b0, 3'b000, 3'b010},
      '{2'd0, 32'h12345678, 4'd10, 4'd0,  1'b0, 1'b1, 3'b000, 3'b001},
      '{2'd0, 32'h00000000, 4'd11, 4'd0,  1'b0, 1'b0, 3'b000, 3'b100},
      '{2'd0, 32'hDEADBEEF, 4'd2,  4'd0,  1'b1, 1'b1, 3'b000, 3'b011},
      '{2'd1, 32'h0,        4'd0,  4'd4,  1'b0, 1'b0, 3'b010, 3'b000},
      '{2'd1, 32'h0,        4'd3,  4'd10, 1'b0, 1'b0, 3'b101, 3'b010},
      '{2'd1, 32'h0,        4'd4,  4'd0,  1'b0, 1'b0, 3'b010, 3'b100},
      '{2'd1, 32'h0,        4'd1,  4'd0,  1'b0, 1'b1, 3'b010, 3'b001},
      '{2'd1, 32'h0,        4'd2,  4'd11, 1'b0, 1'b0, 3'b010, 3'b100},
      '{2'd1, 32'h0,        4'd0,  4'd11, 1'b0, 1'b1, 3'b011, 3'b111},
      '{2'd2, 32'h0,        4'd0,  4'd10, 1'b0, 1'b0, 3'b000, 3'b000},
      '{2'd2, 32'h0,        4'd0,  4'd11, 1'b0, 1'b0, 3'b000, 3'b100},
      '{2'd2, 32'h0,        4'd0,  4'd0,  1'b0, 1'b0, 3'b000, 3'b000}
   };

   function automatic logic [15:0] crc_of(input logic [31:0] d);
      logic [15:0] c = 16'h0000;
      for (int i = 31; i >= 0; i--) begin
         logic fb = c[15] ^ d[i];
         c = {c[14:0], 1'b0};
         if (fb) c = c ^ 16'h1021;
      end
      return c;
   endfunction

   task automatic check3(input string req, input logic [2:0] act, input logic [2:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: err_flags actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: idle actual %b expected %b", req, act, exp);
      end
   endtask

   // One bit per cycle, set at the falling edge; the next rising edge samples it.
   task automatic drive(input logic b);
      @(negedge clk);
      dat0 = b; rd_start = 1'b0; wr_start = 1'b0; busy_start = 1'b0; clr_stb = 1'b0;
   endtask

   task automatic start(input logic r, input logic w, input logic b);
      @(negedge clk);
      dat0 = 1'b1; rd_start = r; wr_start = w; busy_start = b; clr_stb = 1'b0;
   endtask

   task automatic read_body(input logic [31:0] d, input int gap, input logic bad_crc,
                            input logic bad_end, input int inj);
      logic [15:0] c = crc_of(d) ^ (bad_crc ? 16'h0001 : 16'h0000);
      if (gap > LIM) begin
         repeat (gap) drive(1'b1);
         return;
      end
      repeat (gap) drive(1'b1);
      drive(1'b0);
      for (int i = 31; i >= 0; i--) begin
         drive(d[i]);
         if (31 - i == inj) begin
            wr_start = 1'b1; busy_start = 1'b1;
         end
      end
      for (int i = 15; i >= 0; i--) drive(c[i]);
      drive(~bad_end);
   endtask

   task automatic write_body(input logic [2:0] tok, input int gap, input logic bad_end,
                             input int busy);
      if (gap >= TOK_WIN) begin
         repeat (gap + 1) drive(1'b1);
         return;
      end
      repeat (gap) drive(1'b1);
      drive(1'b0);
      for (int i = 2; i >= 0; i--) drive(tok[i]);
      drive(~bad_end);
      repeat (busy) drive(1'b0);
   endtask

   task automatic settle();
      repeat (4) drive(1'b1);
   endtask

   task automatic clear(input logic [2:0] m);
      @(negedge clk);
      clr_stb = 1'b1; clr_mask = m; dat0 = 1'b1;
      drive(1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check3("R1", err_flags, 3'b000);
      check1("R1", idle, 1'b1);
      rst_n = 1'b1;
      drive(1'b1);
      check3("R1", err_flags, 3'b000);

      foreach (VEC[k]) begin
         string tag;
         tag = (VEC[k].op == 2'd0) ? "R2 R3 R4" : (VEC[k].op == 2'd1) ? "R5 R6 R7" : "R8";
         if (VEC[k].op == 2'd0) begin
            start(1'b1, 1'b0, 1'b0);
            read_body(VEC[k].data, int'(VEC[k].gap), VEC[k].bad_crc, VEC[k].bad_end, -1);
         end else if (VEC[k].op == 2'd1) begin
            start(1'b0, 1'b1, 1'b0);
            write_body(VEC[k].tok, int'(VEC[k].gap), VEC[k].bad_end, int'(VEC[k].busy));
         end else begin
            start(1'b0, 1'b0, 1'b1);
            repeat (int'(VEC[k].busy)) drive(1'b0);
         end
         settle();
         check3(tag, err_flags, VEC[k].exp);
         check1("R11", idle, 1'b1);
         clear(3'b111);
         check3("R9", err_flags, 3'b000);
      end

      // R11: idle drops while a phase runs
      start(1'b1, 1'b0, 1'b0);
      drive(1'b1);
      check1("R11", idle, 1'b0);
      read_body(32'h5A5A5A5A, 0, 1'b0, 1'b0, -1);
      settle();
      check3("R2", err_flags, 3'b000);

      // R9: sticky across a clean transfer, mask 0 keeps, partial clear
      start(1'b1, 1'b0, 1'b0);
      read_body(32'h0F0F0F0F, 1, 1'b1, 1'b0, -1);
      settle();
      start(1'b1, 1'b0, 1'b0);
      read_body(32'h0, 12, 1'b0, 1'b0, -1);
      settle();
      check3("R9", err_flags, 3'b110);
      start(1'b1, 1'b0, 1'b0);
      read_body(32'h13579BDF, 2, 1'b0, 1'b0, -1);
      settle();
      check3("R9", err_flags, 3'b110);
      clear(3'b000);
      check3("R9", err_flags, 3'b110);
      clear(3'b010);
      check3("R9", err_flags, 3'b100);
      clear(3'b101);
      check3("R9", err_flags, 3'b000);

      // R10: starts during an active read are ignored (no token wait follows)
      start(1'b1, 1'b0, 1'b0);
      read_body(32'hC3C3C3C3, 1, 1'b0, 1'b0, 5);
      drive(1'b1);
      check1("R10", idle, 1'b1);
      repeat (8) drive(1'b1);
      check3("R10", err_flags, 3'b000);

      // R10: read wins over write when pulsed together; payload begins 111
      start(1'b1, 1'b1, 1'b1);
      read_body(32'hF0F0F0F0, 2, 1'b0, 1'b0, -1);
      settle();
      check3("R10", err_flags, 3'b000);
      check1("R10", idle, 1'b1);

      // R4: a zero limit still accepts a start bit in the first sample
      tmo_limit = '0;
      start(1'b1, 1'b0, 1'b0);
      read_body(32'h89ABCDEF, 0, 1'b0, 1'b0, -1);
      settle();
      check3("R4", err_flags, 3'b000);
      tmo_limit = TMO_W'(LIM);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual running expected done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule